// File: doc/BRIEF.md
# Multi-Segment CRC Frame Checker

This block checks received frames one bit per cycle against a cyclic redundancy code. Each frame is cut into a fixed number of equal subframes. Every subframe carries payload bits first and then a trailing checksum of `WIDTH` bits. The checker forwards the payload bits of every subframe and drops the checksum bits. When a subframe ends it emits a one-cycle strobe. The strobe carries the subframe index and a pass/fail flag for that subframe.

The generator polynomial, register width, preset value, output XOR mask, byte reflection, checksum reflection, division method, subframe count and subframe length are all elaboration parameters. Nothing can be changed at run time. The division register is preset again at the start of every subframe, so the subframes are checked independently. The input is a valid/bit stream with a frame-start marker on the first bit.

Top module: `crc_frame_checker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` and `flag_valid` are 0.
- R2: A frame starts with a bit accepted while `in_valid` and `in_start` are both 1. A frame is `SEGS` subframes of `SEG_BITS` accepted bits each. Cycles with `in_valid` low are skipped. Bits offered after a frame's last bit and before the next `in_start` are ignored: no `out_valid`, no `flag_valid`.
- R3: The first `SEG_BITS-WIDTH` accepted bits of each subframe appear in order on `out_bit`, with `out_valid` high, one cycle after they are accepted. Checksum bits never appear on the output.
- R4: One cycle after the last bit of a subframe is accepted, `flag_valid` is high for one cycle. In that cycle `flag_seg` gives the subframe index (0 for the first subframe). `flag_err` is 0 when the received checksum equals the recomputed one and 1 otherwise.
- R5: The `POLY` parameter holds `WIDTH+1` coefficients in descending power, and its top bit is 1. With `DIRECT=1` the remainder is (preset·x^P + M·x^WIDTH) mod POLY, where P is the payload length and M is the payload taken first bit = highest power.
- R6: With `DIRECT=0` the register starts at the preset value and takes the payload followed by `WIDTH` zero bits. When a 1 leaves the top stage, the register is XORed with the low `WIDTH` coefficients. The remainder is the register contents at the end.
- R7: The division register is loaded with `INIT` at the first bit of every subframe.
- R8: With `REFLECT_IN=1`, the 8 bits of each payload byte enter the divider in the reverse of their arrival order. The payload length must be a multiple of 8.
- R9: The recomputed checksum is the remainder, bit-reversed over `WIDTH` bits when `REFLECT_OUT=1`, then XORed with `FINAL_XOR`. The received checksum arrives most significant bit first.
- R10: An `in_start` in the middle of a frame abandons that frame without any flag and begins a new frame with that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input bit is present this cycle |
| in_start | input | 1 | Marks the first bit of a frame |
| in_bit | input | 1 | Received serial bit |
| out_valid | output | 1 | Payload bit present on out_bit |
| out_bit | output | 1 | Payload bit with checksums removed |
| flag_valid | output | 1 | One-cycle strobe at the end of a subframe |
| flag_err | output | 1 | 1 when that subframe's checksum mismatched |
| flag_seg | output | SEG_IDX_W | Index of the subframe being flagged |

## Verification
A wrong position or subframe count shows up at once. A checksum bit leaks onto `out_valid`, a payload bit goes missing, or `flag_valid` arrives with the wrong `flag_seg`, all within the same subframe. A wrong divider state, reflection order or final mask stays hidden until the end of the subframe. It then appears as a flipped `flag_err`: a clean subframe fails, or a corrupted one passes. The stimulus therefore pairs clean frames with frames corrupted in the payload and in the checksum, for both division methods. It also checks one value against a widely published CRC of a known string.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;

  localparam int MAXW = 32;

  // Mask selecting the low w bits of a working word.
  function automatic logic [MAXW-1:0] wmask(input int w);
    logic [MAXW-1:0] m;
    m = '0;
    for (int i = 0; i < MAXW; i++) begin
      if (i < w) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Feedback taken from top stage XOR incoming bit (no augmentation needed).
  function automatic logic [MAXW-1:0] step_direct(input logic [MAXW-1:0] s,
                                                  input logic b,
                                                  input logic [MAXW-1:0] poly,
                                                  input int w);
    logic fb;
    logic [MAXW-1:0] n;
    fb = s[w-1] ^ b;
    n  = (s << 1) & wmask(w);
    if (fb) n = n ^ poly;
    return n;
  endfunction

  // Long-division step: bit enters at the bottom, the top stage decides the subtraction.
  function automatic logic [MAXW-1:0] step_aug(input logic [MAXW-1:0] s,
                                               input logic b,
                                               input logic [MAXW-1:0] poly,
                                               input int w);
    logic top;
    logic [MAXW-1:0] n;
    top = s[w-1];
    n   = ((s << 1) | {{(MAXW-1){1'b0}}, b}) & wmask(w);
    if (top) n = n ^ poly;
    return n;
  endfunction

  // Mirror the low w bits about their centre.
  function automatic logic [MAXW-1:0] mirror(input logic [MAXW-1:0] v, input int w);
    logic [MAXW-1:0] r;
    r = '0;
    for (int i = 0; i < MAXW; i++) begin
      if (i < w) r[i] = v[w-1-i];
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_seg_tracker.sv
module crc_seg_tracker #(
  parameter int SEGS     = 2,
  parameter int SEG_BITS = 48,
  parameter int PAY      = 32,
  localparam int PW      = $clog2(SEG_BITS),
  localparam int SW      = (SEGS > 1) ? $clog2(SEGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_start,
  output logic          acc,
  output logic          seg_first,
  output logic          is_pay,
  output logic          is_last,
  output logic          frame_end,
  output logic [SW-1:0] seg_idx
);

  localparam logic [PW-1:0] PAY_L  = PW'(PAY);
  localparam logic [PW-1:0] LAST_L = PW'(SEG_BITS - 1);
  localparam logic [SW-1:0] SEGL_L = SW'(SEGS - 1);

  logic          armed_q;
  logic [PW-1:0] pos_q, pos_c;
  logic [SW-1:0] seg_q, seg_c;

  // A start bit always restarts counting, even mid-frame.
  assign pos_c     = in_start ? '0 : pos_q;
  assign seg_c     = in_start ? '0 : seg_q;
  assign acc       = in_valid && (in_start || armed_q);
  assign seg_first = (pos_c == '0);
  assign is_pay    = (pos_c < PAY_L);
  assign is_last   = (pos_c == LAST_L);
  assign frame_end = is_last && (seg_c == SEGL_L);
  assign seg_idx   = seg_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pos_q   <= '0;
      seg_q   <= '0;
    end else if (acc) begin
      armed_q <= !frame_end;
      pos_q   <= is_last ? '0 : pos_c + 1'b1;
      if (is_last) seg_q <= frame_end ? '0 : seg_c + 1'b1;
      else         seg_q <= seg_c;
    end
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_L); // R2
  AST_SEG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    seg_q <= SEGL_L); // R2

endmodule

// File: rtl/crc_byte_feeder.sv
module crc_byte_feeder #(
  parameter bit REFLECT_IN = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pay_acc,
  input  logic       seg_first,
  input  logic       in_bit,
  output logic       feed_en,
  output logic       feed8,
  output logic [7:0] feed_word
);

  generate
    if (REFLECT_IN) begin : g_reflect
      logic [6:0] hold_q;
      logic [2:0] cnt_q, cnt_c;

      assign cnt_c   = seg_first ? 3'd0 : cnt_q;
      assign feed_en = pay_acc && (cnt_c == 3'd7);
      assign feed8   = 1'b1;

      // Entry order is newest first: word[7] enters first.
      always_comb begin
        feed_word[7] = in_bit;
        for (int k = 0; k < 7; k++) feed_word[6-k] = hold_q[k];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hold_q <= '0;
          cnt_q  <= '0;
        end else if (pay_acc) begin
          hold_q <= {hold_q[5:0], in_bit};
          cnt_q  <= cnt_c + 3'd1;
        end
      end
    end else begin : g_plain
      logic unused_sink;
      assign unused_sink = ^{clk, rst_n, seg_first};
      assign feed_en     = pay_acc;
      assign feed8       = 1'b0;
      assign feed_word   = {in_bit, 7'b0};
    end
  endgenerate

  AST_FEED_ONLY_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    feed_en |-> pay_acc); // R8

endmodule

// File: rtl/crc_div_engine.sv
module crc_div_engine #(
  parameter int              WIDTH  = 16,
  parameter logic [WIDTH:0]  POLY   = 17'h11021,
  parameter logic [WIDTH-1:0] INIT  = '0,
  parameter bit              DIRECT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             seg_first,
  input  logic             feed_en,
  input  logic             feed8,
  input  logic [7:0]       feed_word,
  input  logic             zero_en,
  output logic [WIDTH-1:0] rem_next
);
  import crc_chk_pkg::*;

  localparam logic [MAXW-1:0] POLY_W = MAXW'(POLY[WIDTH-1:0]);
  localparam logic [MAXW-1:0] INIT_W = MAXW'(INIT);

  logic [MAXW-1:0] state_q, base, nxt;

  assign base = seg_first ? INIT_W : state_q;

  generate
    if (DIRECT) begin : g_direct
      logic unused_zero;
      assign unused_zero = zero_en;
      always_comb begin
        nxt = base;
        if (feed_en) begin
          for (int i = 0; i < 8; i++) begin
            if (feed8 || i == 0) nxt = step_direct(nxt, feed_word[7-i], POLY_W, WIDTH);
          end
        end
      end
    end else begin : g_augmented
      always_comb begin
        nxt = base;
        if (feed_en) begin
          for (int i = 0; i < 8; i++) begin
            if (feed8 || i == 0) nxt = step_aug(nxt, feed_word[7-i], POLY_W, WIDTH);
          end
        end
        // One appended zero per checksum bit slot: WIDTH zeros per subframe.
        if (zero_en) nxt = step_aug(nxt, 1'b0, POLY_W, WIDTH);
      end
    end
  endgenerate

  assign rem_next = nxt[WIDTH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= '0;
    else if (acc) state_q <= nxt;
  end

  AST_STATE_IN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q & ~wmask(WIDTH)) == '0); // R5

endmodule

// File: rtl/crc_frame_checker.sv
module crc_frame_checker #(
  parameter int               WIDTH       = 16,
  parameter logic [WIDTH:0]   POLY        = 17'h11021,
  parameter logic [WIDTH-1:0] INIT        = '0,
  parameter logic [WIDTH-1:0] FINAL_XOR   = '0,
  parameter bit               REFLECT_IN  = 1'b0,
  parameter bit               REFLECT_OUT = 1'b0,
  parameter bit               DIRECT      = 1'b1,
  parameter int               SEGS        = 2,
  parameter int               SEG_BITS    = 48,
  localparam int              SEG_IDX_W   = (SEGS > 1) ? $clog2(SEGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_start,
  input  logic                 in_bit,
  output logic                 out_valid,
  output logic                 out_bit,
  output logic                 flag_valid,
  output logic                 flag_err,
  output logic [SEG_IDX_W-1:0] flag_seg
);
  import crc_chk_pkg::*;

  localparam int PAY = SEG_BITS - WIDTH;

  logic                 acc, seg_first, is_pay, is_last, frame_end;
  logic [SEG_IDX_W-1:0] seg_idx;
  logic                 pay_acc, chk_acc;
  logic                 feed_en, feed8;
  logic [7:0]           feed_word;
  logic [WIDTH-1:0]     rem_next, rx_q, rx_now, want;

  crc_seg_tracker #(.SEGS(SEGS), .SEG_BITS(SEG_BITS), .PAY(PAY)) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .acc(acc), .seg_first(seg_first), .is_pay(is_pay), .is_last(is_last),
    .frame_end(frame_end), .seg_idx(seg_idx)
  );

  assign pay_acc = acc && is_pay;
  assign chk_acc = acc && !is_pay;

  crc_byte_feeder #(.REFLECT_IN(REFLECT_IN)) u_feed (
    .clk(clk), .rst_n(rst_n), .pay_acc(pay_acc), .seg_first(seg_first),
    .in_bit(in_bit), .feed_en(feed_en), .feed8(feed8), .feed_word(feed_word)
  );

  crc_div_engine #(.WIDTH(WIDTH), .POLY(POLY), .INIT(INIT), .DIRECT(DIRECT)) u_div (
    .clk(clk), .rst_n(rst_n), .acc(acc), .seg_first(seg_first),
    .feed_en(feed_en), .feed8(feed8), .feed_word(feed_word),
    .zero_en(chk_acc), .rem_next(rem_next)
  );

  // Received checksum, most significant bit first, completed by the live bit.
  assign rx_now = {rx_q[WIDTH-2:0], in_bit};

  always_comb begin
    logic [MAXW-1:0] r;
    r = MAXW'(rem_next);
    if (REFLECT_OUT) r = mirror(r, WIDTH);
    want = r[WIDTH-1:0] ^ FINAL_XOR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q       <= '0;
      out_valid  <= 1'b0;
      out_bit    <= 1'b0;
      flag_valid <= 1'b0;
      flag_err   <= 1'b0;
      flag_seg   <= '0;
    end else begin
      if (chk_acc) rx_q <= rx_now;
      out_valid  <= pay_acc;
      out_bit    <= pay_acc ? in_bit : 1'b0;
      flag_valid <= acc && is_last;
      flag_err   <= (acc && is_last) ? (want != rx_now) : 1'b0;
      flag_seg   <= (acc && is_last) ? seg_idx : '0;
    end
  end

  AST_NO_CHK_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && flag_valid)); // R3
  AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_valid |=> !flag_valid); // R4
  AST_QUIET_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (!out_valid && !flag_valid)); // R2
  AST_ERR_ONLY_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_err |-> flag_valid); // R4
  AST_FRAME_LAST_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && frame_end) |=> (flag_valid && flag_seg == SEG_IDX_W'(SEGS - 1))); // R4

endmodule

// File: tb/crc_frame_checker_tb.sv
module crc_frame_checker_tb;
  localparam int CLK_PERIOD = 10;

  // Configuration A: direct method, all-ones preset.
  localparam int          A_W = 16, A_SB = 88, A_SEGS = 2, A_PAY = A_SB - A_W;
  localparam logic [16:0] A_POLY = 17'h11021;
  localparam logic [15:0] A_INIT = 16'hFFFF, A_FX = 16'h0000;
  // Configuration B: augmented method, byte and checksum reflection, output mask.
  localparam int          B_W = 8, B_SB = 40, B_SEGS = 3, B_PAY = B_SB - B_W;
  localparam logic [8:0]  B_POLY = 9'h107;
  localparam logic [7:0]  B_INIT = 8'h5A, B_FX = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0, in_bit = 1'b0;
  logic a_valid = 1'b0, a_start = 1'b0, b_valid = 1'b0, b_start = 1'b0;
  logic a_ov, a_ob, a_fv, a_fe, b_ov, b_ob, b_fv, b_fe;
  logic       a_fs;
  logic [1:0] b_fs;

  int checks = 0, fails = 0, cyc = 0;
  int flags_a = 0, pays_a = 0, flags_b = 0;
  bit qa_pay[$], qb_pay[$];
  int qa_flag[$], qb_flag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_frame_checker #(.WIDTH(A_W), .POLY(A_POLY), .INIT(A_INIT), .FINAL_XOR(A_FX),
    .REFLECT_IN(1'b0), .REFLECT_OUT(1'b0), .DIRECT(1'b1), .SEGS(A_SEGS), .SEG_BITS(A_SB)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(a_valid), .in_start(a_start), .in_bit(in_bit),
    .out_valid(a_ov), .out_bit(a_ob), .flag_valid(a_fv), .flag_err(a_fe), .flag_seg(a_fs));

  crc_frame_checker #(.WIDTH(B_W), .POLY(B_POLY), .INIT(B_INIT), .FINAL_XOR(B_FX),
    .REFLECT_IN(1'b1), .REFLECT_OUT(1'b1), .DIRECT(1'b0), .SEGS(B_SEGS), .SEG_BITS(B_SB)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_start(b_start), .in_bit(in_bit),
    .out_valid(b_ov), .out_bit(b_ob), .flag_valid(b_fv), .flag_err(b_fe), .flag_seg(b_fs));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: polynomial long division over an explicit bit array.
  function automatic logic [31:0] model_crc(input logic [0:511] msg, input int plen, input int w,
      input logic [32:0] poly, input logic [31:0] init, input logic [31:0] fx,
      input bit refin, input bit refout, input bit direct);
    logic [0:1023] a;
    logic [31:0] r, m;
    int off, n, src;
    a = '0;
    off = direct ? 0 : w;
    if (!direct) for (int k = 0; k < w; k++) a[k] = init[w-1-k];
    for (int i = 0; i < plen; i++) begin
      src = refin ? ((i / 8) * 8 + 7 - (i % 8)) : i;
      a[off+i] = msg[src];
    end
    n = off + plen + w;
    if (direct) for (int k = 0; k < w; k++) a[k] = a[k] ^ init[w-1-k];
    for (int i = 0; i < n - w; i++) begin
      if (a[i]) for (int k = 0; k <= w; k++) a[i+k] = a[i+k] ^ poly[w-k];
    end
    r = '0;
    for (int k = 0; k < w; k++) r[w-1-k] = a[n-w+k];
    if (refout) begin
      m = '0;
      for (int k = 0; k < w; k++) m[k] = r[w-1-k];
      r = m;
    end
    return r ^ fx;
  endfunction

  function automatic logic [31:0] model_for(input int dut, input logic [0:511] msg);
    if (dut == 0) return model_crc(msg, A_PAY, A_W, 33'(A_POLY), 32'(A_INIT), 32'(A_FX), 1'b0, 1'b0, 1'b1);
    return model_crc(msg, B_PAY, B_W, 33'(B_POLY), 32'(B_INIT), 32'(B_FX), 1'b1, 1'b1, 1'b0);
  endfunction

  task automatic drive(input int dut, input logic v, input logic s, input logic b);
    @(negedge clk);
    in_bit  = b;
    a_valid = (dut == 0) ? v : 1'b0;
    a_start = (dut == 0) ? s : 1'b0;
    b_valid = (dut == 1) ? v : 1'b0;
    b_start = (dut == 1) ? s : 1'b0;
  endtask

  // Driver: builds a frame with correct checksums, optionally corrupts one bit,
  // sends it and pushes the expected payload bits and flags to the scoreboard.
  task automatic run_frame(input int dut, input logic [0:511] pl, input int flip,
                           input int abort_at, input bit gaps);
    int w, sb, pay, ns, lim, pos, seg;
    logic [0:511] fr, msg;
    logic [31:0] c, rxv;
    bit err;
    w   = (dut == 0) ? A_W : B_W;
    sb  = (dut == 0) ? A_SB : B_SB;
    ns  = (dut == 0) ? A_SEGS : B_SEGS;
    pay = sb - w;
    fr  = '0;
    for (int s = 0; s < ns; s++) begin
      msg = '0;
      for (int i = 0; i < pay; i++) msg[i] = pl[s*pay+i];
      c = model_for(dut, msg);
      for (int i = 0; i < pay; i++) fr[s*sb+i] = msg[i];
      for (int k = 0; k < w; k++) fr[s*sb+pay+k] = c[w-1-k];
    end
    if (flip >= 0) fr[flip] = ~fr[flip];
    lim = (abort_at >= 0) ? abort_at : ns * sb;
    for (int i = 0; i < lim; i++) begin
      if (gaps && (i % 7 == 3)) drive(dut, 1'b0, 1'b0, ~fr[i]);
      pos = i % sb;
      seg = i / sb;
      if (pos < pay) begin
        if (dut == 0) qa_pay.push_back(fr[i]); else qb_pay.push_back(fr[i]);
      end
      if (pos == sb - 1) begin
        msg = '0;
        for (int j = 0; j < pay; j++) msg[j] = fr[seg*sb+j];
        c = model_for(dut, msg);
        rxv = '0;
        for (int k = 0; k < w; k++) rxv[w-1-k] = fr[seg*sb+pay+k];
        err = (c != rxv);
        if (dut == 0) qa_flag.push_back(seg * 2 + int'(err));
        else          qb_flag.push_back(seg * 2 + int'(err));
      end
      drive(dut, 1'b1, (i == 0), fr[i]);
    end
    drive(dut, 1'b0, 1'b0, 1'b0);
  endtask

  // Monitors: pop and compare as the outputs appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (a_ov) begin
        pays_a++;
        if (qa_pay.size() == 0) check(1'b0, "R3 A payload bit with none expected", 32'(a_ob), 0);
        else begin
          bit e; e = qa_pay.pop_front();
          check(a_ob == e, "R3 A payload bit", 32'(a_ob), 32'(e));
        end
      end
      if (a_fv) begin
        flags_a++;
        if (qa_flag.size() == 0) check(1'b0, "R4 A flag with none expected", 32'(a_fe), 0);
        else begin
          int e; e = qa_flag.pop_front();
          check(int'(a_fs) * 2 + int'(a_fe) == e, "R4 R5 R7 A flag seg*2+err",
                32'(int'(a_fs) * 2 + int'(a_fe)), 32'(e));
        end
      end
      if (b_ov) begin
        if (qb_pay.size() == 0) check(1'b0, "R3 B payload bit with none expected", 32'(b_ob), 0);
        else begin
          bit e; e = qb_pay.pop_front();
          check(b_ob == e, "R3 B payload bit", 32'(b_ob), 32'(e));
        end
      end
      if (b_fv) begin
        flags_b++;
        if (qb_flag.size() == 0) check(1'b0, "R4 B flag with none expected", 32'(b_fe), 0);
        else begin
          int e; e = qb_flag.pop_front();
          check(int'(b_fs) * 2 + int'(b_fe) == e, "R4 R6 R8 R9 B flag seg*2+err",
                32'(int'(b_fs) * 2 + int'(b_fe)), 32'(e));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 60000) begin
      check(1'b0, "watchdog expired", 32'(cyc), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [0:511] pa, pb;
    int f0, p0;
    pa = {72'h313233343536373839, 72'hDEADBEEF0123456789, 368'b0};
    pb = {96'h0F1E2D3C4B5A69788796A5B4, 416'b0};

    repeat (3) @(negedge clk);
    check(!a_ov && !a_fv && !b_ov && !b_fv, "R1 outputs low in reset",
          32'({a_ov, a_fv, b_ov, b_fv}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!a_ov && !a_fv && !b_ov && !b_fv, "R1 outputs low after reset",
          32'({a_ov, a_fv, b_ov, b_fv}), 0);

    // Anchor the reference on a widely published value for "123456789".
    check(model_for(0, pa) == 32'h29B1, "R5 reference on known string",
          model_for(0, pa), 32'h29B1);

    run_frame(0, pa, -1, -1, 1'b0);       // clean: 0,0 (R5 R7)
    run_frame(0, pa, 100, -1, 1'b0);      // payload error in subframe 1
    run_frame(0, pa, 75, -1, 1'b0);       // checksum error in subframe 0

    // R2: bits with no start after a completed frame are ignored.
    repeat (4) @(negedge clk);
    f0 = flags_a; p0 = pays_a;
    for (int i = 0; i < 20; i++) drive(0, 1'b1, 1'b0, i[0]);
    drive(0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check(flags_a == f0 && pays_a == p0, "R2 bits outside a frame ignored",
          32'(flags_a - f0 + pays_a - p0), 0);

    // R10: abandon a frame part-way, then restart with a clean frame.
    f0 = flags_a;
    run_frame(0, pa, -1, 30, 1'b0);
    run_frame(0, pa, -1, -1, 1'b0);
    repeat (3) @(negedge clk);
    check(flags_a - f0 == A_SEGS, "R10 flag count after restart", 32'(flags_a - f0), A_SEGS);

    run_frame(1, pb, -1, -1, 1'b1);       // clean with gaps (R2 R6 R8 R9)
    run_frame(1, pb, 45, -1, 1'b0);       // payload error, subframe 1
    run_frame(1, pb, 39, -1, 1'b1);       // last checksum bit of subframe 0
    run_frame(1, pb, 113, -1, 1'b0);      // checksum error, subframe 2

    repeat (5) @(negedge clk);
    check(flags_b == 4 * B_SEGS, "R4 B flag count", 32'(flags_b), 32'(4 * B_SEGS));
    check(qa_pay.size() + qb_pay.size() == 0, "R3 all payload bits delivered",
          32'(qa_pay.size() + qb_pay.size()), 0);
    check(qa_flag.size() + qb_flag.size() == 0, "R4 all flags delivered",
          32'(qa_flag.size() + qb_flag.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule